// File: doc/BRIEF.md
# Paged Extended Memory Access Bridge

This block lets a host processor with a 16-bit address bus reach a 33-bit external address space. The host first loads two page registers through ordinary register accesses. The upper page register holds the top thirteen address bits. The lower page register holds the next few address bits, together with a two-bit byte-write mask and a two-bit parity field. After that, every access made with the data-access strobe asserted goes to external memory. The in-page offset comes straight from the host address bus, and the data passes directly on the host data bus.

The host bus can run in a 16-bit or an 8-bit data mode, and the mode moves the page boundary. In 16-bit mode the page register supplies address bits 19..16 and the offset supplies bits 15..0. In 8-bit mode the page register supplies bits 19..15 and the offset supplies bits 14..0. The page registers keep their values, so any number of accesses to the same page need no reload. The parity bits returned by the last extended read can be read back through a status register.

Top module: `xpage_bridge`

A small state machine controls every access. It has four states:
- `ST_IDLE` waits for a request.
- `ST_WR_PULSE` drives the external write strobe.
- `ST_RD_ISSUE` drives the external read strobe.
- `ST_RESP` presents read data to the host.

It has these transitions:
- *accept-write* goes from `ST_IDLE` to `ST_WR_PULSE`.
- *accept-read* goes from `ST_IDLE` to `ST_RD_ISSUE`.
- *reg-read* goes from `ST_IDLE` to `ST_RESP`.
- *reg-write* stays in `ST_IDLE`.
- *write-done* goes from `ST_WR_PULSE` to `ST_IDLE`.
- *data-capture* goes from `ST_RD_ISSUE` to `ST_RESP`.
- *respond* goes from `ST_RESP` to `ST_IDLE`.

A request is accepted only in `ST_IDLE`.

## Requirements
- R1: After reset, all page and status registers read as zero. `mem_we`, `mem_re` and `host_rvalid` are low.
- R2: A register write (strobe low, `host_wr`=1) to host address 0x0008 stores `host_wdata[12:0]` as address bits [32:20]. This register reads back as `{3'b0, bits}`.
- R3: In 16-bit mode (`host_wide`=1), an extended access drives `mem_addr` = {upper[12:0], lower[3:0], host_addr[15:0]}.
- R4: In 8-bit mode (`host_wide`=0), an extended access drives `mem_addr` = {upper[12:0], lower[4:0], host_addr[14:0]}. `host_addr[15]` has no effect on the access.
- R5: A register write to 0x000A stores the page field from `wdata[4:0]`, the byte-write mask from [13:12] and the parity field from [15:14]. Bits [11:5] are ignored and read back as zero. In 16-bit mode, page bit 4 does not affect `mem_addr`.
- R6: An access with the data-access strobe low never raises `mem_we` or `mem_re`.
- R7: An accepted extended write raises `mem_we` for exactly the one cycle after the accepting edge. During that cycle, `mem_be` equals the mask, `mem_wdata` equals the host data and `mem_wpar` equals the parity field. A mask of 00 raises no `mem_we`.
- R8: An accepted extended read raises `mem_re` for the one cycle after the accepting edge. `mem_rdata` is captured at the next edge and presented on `host_rdata` with `host_rvalid` high for one cycle.
- R9: A register read of 0x0000 returns `{rpar, 14'b0}`, where rpar is the `mem_rpar` value captured by the most recent extended read.
- R10: The page registers hold their contents across extended accesses, so successive accesses use the same page without a reload.
- R11: A request presented while an access is in progress (`ST_WR_PULSE`, `ST_RD_ISSUE` or `ST_RESP`) is ignored.
- R12: A register read is answered in the cycle after the accepting edge, with `host_rvalid` high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wide | input | 1 | 1 = 16-bit host mode, 0 = 8-bit host mode |
| host_sel | input | 1 | Request valid for one cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_das | input | 1 | Data-access strobe: 1 = extended space, 0 = registers |
| host_addr | input | 16 | Register offset or in-page offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data to the host |
| host_rvalid | output | 1 | Read data valid |
| mem_addr | output | 33 | Composed external address |
| mem_we | output | 1 | External write strobe |
| mem_re | output | 1 | External read strobe |
| mem_be | output | 2 | Byte-write mask |
| mem_wdata | output | 16 | External write data |
| mem_wpar | output | 2 | Parity field sent with writes |
| mem_rdata | input | 16 | External read data |
| mem_rpar | input | 2 | Parity returned with reads |

## Verification
The hardest case to reach is a request that arrives while an extended read is still in progress. The host interface gives no busy signal, so the bench has to time this case on purpose. It starts an extended read and, one cycle later during the issue cycle, presents a register write to the upper page register. It then reads that register back and expects the old value. A related case is the dependence on mode: the same page contents must give different addresses. The bench therefore re-runs accesses with offset bit 15 set and with page bit 4 set in both modes. This shows which bits the active mode ignores.

// File: rtl/xpb_pkg.sv
package xpb_pkg;

    localparam int HOST_AW   = 16;
    localparam int HOST_DW   = 16;
    localparam int EXT_AW    = 33;
    localparam int UPPER_W   = 13;
    localparam int PAGE_LO_W = 5;
    localparam int MASK_W    = 2;
    localparam int PAR_W     = 2;

    localparam logic [HOST_AW-1:0] OFS_STATUS = 16'h0000;
    localparam logic [HOST_AW-1:0] OFS_UPPER  = 16'h0008;
    localparam logic [HOST_AW-1:0] OFS_LOWER  = 16'h000A;

    // field positions inside the lower page word
    localparam int LO_MASK_LSB = 12;
    localparam int LO_PAR_LSB  = 14;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WR_PULSE = 2'd1,
        ST_RD_ISSUE = 2'd2,
        ST_RESP     = 2'd3
    } xpb_state_e;

endpackage

// File: rtl/xpb_page_regs.sv
module xpb_page_regs
    import xpb_pkg::*;
#(
    parameter int DW  = HOST_DW,
    parameter int AW  = HOST_AW,
    parameter int UW  = UPPER_W,
    parameter int LW  = PAGE_LO_W,
    parameter int MW  = MASK_W,
    parameter int PW  = PAR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_upper,
    input  logic          wr_lower,
    input  logic [DW-1:0] wdata,
    input  logic          rpar_load,
    input  logic [PW-1:0] rpar_in,
    input  logic [AW-1:0] rd_ofs,
    output logic [DW-1:0] rd_word,
    output logic [UW-1:0] upper_q,
    output logic [LW-1:0] page_lo_q,
    output logic [MW-1:0] mask_q,
    output logic [PW-1:0] wpar_q
);

    localparam int UPPER_PAD  = DW - UW;
    localparam int LOWER_GAP  = LO_MASK_LSB - LW;
    localparam int STATUS_PAD = DW - PW;

    logic [PW-1:0] rpar_q;

    // upper page register: address bits above the low page field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
        end else if (wr_upper) begin
            upper_q <= wdata[UW-1:0];
        end
    end

    // lower page register: page bits, byte mask, parity field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_lo_q <= '0;
            mask_q    <= '0;
            wpar_q    <= '0;
        end else if (wr_lower) begin
            page_lo_q <= wdata[LW-1:0];
            mask_q    <= wdata[LO_MASK_LSB +: MW];
            wpar_q    <= wdata[LO_PAR_LSB +: PW];
        end
    end

    // parity returned by the last extended read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpar_q <= '0;
        end else if (rpar_load) begin
            rpar_q <= rpar_in;
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (rd_ofs)
            OFS_STATUS: rd_word = {rpar_q, {STATUS_PAD{1'b0}}};
            OFS_UPPER:  rd_word = {{UPPER_PAD{1'b0}}, upper_q};
            OFS_LOWER:  rd_word = {wpar_q, mask_q, {LOWER_GAP{1'b0}}, page_lo_q};
            default:    rd_word = '0;
        endcase
    end

endmodule

// File: rtl/xpb_addr_compose.sv
module xpb_addr_compose
    import xpb_pkg::*;
#(
    parameter int EW = EXT_AW,
    parameter int UW = UPPER_W,
    parameter int LW = PAGE_LO_W,
    parameter int OW = HOST_AW
) (
    input  logic          wide,
    input  logic [UW-1:0] upper,
    input  logic [LW-1:0] page_lo,
    input  logic [OW-1:0] offset,
    output logic [EW-1:0] addr
);

    // the two modes move one bit between the page and the offset
    localparam int WIDE_PG   = LW - 1;
    localparam int NARROW_OF = OW - 1;

    logic [EW-1:0] addr_wide;
    logic [EW-1:0] addr_narrow;

    generate
        if (UW + WIDE_PG + OW == EW) begin : g_fit
            assign addr_wide   = {upper, page_lo[WIDE_PG-1:0], offset};
            assign addr_narrow = {upper, page_lo, offset[NARROW_OF-1:0]};
        end else begin : g_pad
            assign addr_wide   = EW'({upper, page_lo[WIDE_PG-1:0], offset});
            assign addr_narrow = EW'({upper, page_lo, offset[NARROW_OF-1:0]});
        end
    endgenerate

    assign addr = wide ? addr_wide : addr_narrow;

endmodule

// File: rtl/xpb_access_fsm.sv
module xpb_access_fsm
    import xpb_pkg::*;
#(
    parameter int AW = HOST_AW,
    parameter int DW = HOST_DW,
    parameter int MW = MASK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wide,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic          host_das,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] reg_word,
    input  logic [MW-1:0] mask,
    input  logic [DW-1:0] mem_rdata,
    output logic          wr_upper,
    output logic          wr_lower,
    output logic          rpar_load,
    output logic          wide_q,
    output logic [AW-1:0] ofs_q,
    output logic [DW-1:0] wdata_q,
    output logic          mem_we,
    output logic          mem_re,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid
);

    xpb_state_e state_q, state_d;
    logic       accept;
    logic       acc_ext_wr, acc_ext_rd, acc_reg_wr, acc_reg_rd;
    logic [DW-1:0] rdata_q;

    assign accept     = host_sel && (state_q == ST_IDLE);
    assign acc_ext_wr = accept &&  host_das &&  host_wr;
    assign acc_ext_rd = accept &&  host_das && !host_wr;
    assign acc_reg_wr = accept && !host_das &&  host_wr;
    assign acc_reg_rd = accept && !host_das && !host_wr;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_ext_wr)      state_d = ST_WR_PULSE;
                else if (acc_ext_rd) state_d = ST_RD_ISSUE;
                else if (acc_reg_rd) state_d = ST_RESP;
                else                 state_d = ST_IDLE;
            end
            ST_WR_PULSE: state_d = ST_IDLE;
            ST_RD_ISSUE: state_d = ST_RESP;
            ST_RESP:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and read-data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q  <= 1'b0;
            ofs_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept && host_das) begin
                wide_q  <= host_wide;
                ofs_q   <= host_addr;
                wdata_q <= host_wdata;
            end
            if (acc_reg_rd) begin
                rdata_q <= reg_word;
            end else if (state_q == ST_RD_ISSUE) begin
                rdata_q <= mem_rdata;
            end
        end
    end

    // outputs per state
    always_comb begin
        mem_we      = 1'b0;
        mem_re      = 1'b0;
        host_rvalid = 1'b0;
        rpar_load   = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_WR_PULSE: mem_we = (mask != '0);
            ST_RD_ISSUE: begin
                mem_re    = 1'b1;
                rpar_load = 1'b1;
            end
            ST_RESP:     host_rvalid = 1'b1;
            default:     ;
        endcase
    end

    assign wr_upper   = acc_reg_wr && (host_addr == OFS_UPPER);
    assign wr_lower   = acc_reg_wr && (host_addr == OFS_LOWER);
    assign host_rdata = rdata_q;

endmodule

// File: rtl/xpage_bridge.sv
module xpage_bridge
    import xpb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wide,
    input  logic                host_sel,
    input  logic                host_wr,
    input  logic                host_das,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [HOST_DW-1:0]  host_wdata,
    output logic [HOST_DW-1:0]  host_rdata,
    output logic                host_rvalid,
    output logic [EXT_AW-1:0]   mem_addr,
    output logic                mem_we,
    output logic                mem_re,
    output logic [MASK_W-1:0]   mem_be,
    output logic [HOST_DW-1:0]  mem_wdata,
    output logic [PAR_W-1:0]    mem_wpar,
    input  logic [HOST_DW-1:0]  mem_rdata,
    input  logic [PAR_W-1:0]    mem_rpar
);

    logic                 wr_upper, wr_lower, rpar_load, wide_q;
    logic [HOST_DW-1:0]   reg_word, wdata_q;
    logic [HOST_AW-1:0]   ofs_q;
    logic [UPPER_W-1:0]   upper_q;
    logic [PAGE_LO_W-1:0] page_lo_q;
    logic [MASK_W-1:0]    mask_q;
    logic [PAR_W-1:0]     wpar_q;

    xpb_page_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_upper  (wr_upper),
        .wr_lower  (wr_lower),
        .wdata     (host_wdata),
        .rpar_load (rpar_load),
        .rpar_in   (mem_rpar),
        .rd_ofs    (host_addr),
        .rd_word   (reg_word),
        .upper_q   (upper_q),
        .page_lo_q (page_lo_q),
        .mask_q    (mask_q),
        .wpar_q    (wpar_q)
    );

    xpb_access_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wide   (host_wide),
        .host_sel    (host_sel),
        .host_wr     (host_wr),
        .host_das    (host_das),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .reg_word    (reg_word),
        .mask        (mask_q),
        .mem_rdata   (mem_rdata),
        .wr_upper    (wr_upper),
        .wr_lower    (wr_lower),
        .rpar_load   (rpar_load),
        .wide_q      (wide_q),
        .ofs_q       (ofs_q),
        .wdata_q     (wdata_q),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    xpb_addr_compose u_compose (
        .wide    (wide_q),
        .upper   (upper_q),
        .page_lo (page_lo_q),
        .offset  (ofs_q),
        .addr    (mem_addr)
    );

    assign mem_be    = mask_q;
    assign mem_wdata = wdata_q;
    assign mem_wpar  = wpar_q;

endmodule

// File: rtl/xpage_bridge_chk.sv
module xpage_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic host_sel,
    input logic host_das,
    input logic host_wr,
    input logic mem_we,
    input logic mem_re,
    input logic host_rvalid
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!mem_we && !mem_re && !host_rvalid));

    assert_we_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(host_sel && host_das && host_wr));

    assert_re_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> $past(host_sel && host_das && !host_wr));

    assert_we_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_no_we_re_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_read_answer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (host_rvalid && !mem_re));

    assert_rvalid_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

endmodule

bind xpage_bridge xpage_bridge_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_sel    (host_sel),
    .host_das    (host_das),
    .host_wr     (host_wr),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .host_rvalid (host_rvalid)
);

// File: tb/sim_xpage_bridge.sv
module sim_xpage_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wide = 1'b1;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_das = 1'b0;
    logic [15:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic [32:0] mem_addr;
    logic        mem_we, mem_re;
    logic [1:0]  mem_be, mem_wpar, mem_rpar;
    logic [15:0] mem_wdata, mem_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // shadow of the page registers
    logic [12:0] sh_up = '0;
    logic [4:0]  sh_pg = '0;
    logic [1:0]  sh_mask = '0;
    logic [1:0]  sh_par = '0;
    logic [1:0]  sh_rpar = '0;

    always #2 clk = ~clk;

    function automatic logic [15:0] mem_fn(input logic [32:0] a);
        return a[15:0] ^ a[31:16] ^ {15'b0, a[32]};
    endfunction

    function automatic logic [1:0] par_fn(input logic [32:0] a);
        return a[1:0] ^ a[17:16];
    endfunction

    function automatic logic [32:0] exp_addr(input logic wide, input logic [15:0] ofs);
        if (wide) return {sh_up, sh_pg[3:0], ofs};
        return {sh_up, sh_pg, ofs[14:0]};
    endfunction

    assign mem_rdata = mem_re ? mem_fn(mem_addr) : 16'hDEAD;
    assign mem_rpar  = mem_re ? par_fn(mem_addr) : 2'b00;

    xpage_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_wide(host_wide), .host_sel(host_sel),
        .host_wr(host_wr), .host_das(host_das), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_wpar(mem_wpar), .mem_rdata(mem_rdata),
        .mem_rpar(mem_rpar)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic das, input logic wr, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_das = das; host_wr = wr; host_addr = a; host_wdata = d;
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [15:0] d);
        drive(1'b0, 1'b1, a, d);
        @(negedge clk);
        host_sel = 1'b0;
        chk("R6 reg write strobes", {mem_we, mem_re}, 2'b00);
        if (a == 16'h0008) sh_up = d[12:0];
        if (a == 16'h000A) begin
            sh_pg = d[4:0]; sh_mask = d[13:12]; sh_par = d[15:14];
        end
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [15:0] v);
        drive(1'b0, 1'b0, a, 16'h0);
        @(negedge clk);
        host_sel = 1'b0;
        chk("R12 reg read valid", host_rvalid, 1'b1);
        chk("R6 reg read strobes", {mem_we, mem_re}, 2'b00);
        v = host_rdata;
        @(negedge clk);
        chk("R12 reg read valid one cycle", host_rvalid, 1'b0);
    endtask

    function automatic logic [15:0] exp_reg(input logic [15:0] a);
        if (a == 16'h0000) return {sh_rpar, 14'b0};
        if (a == 16'h0008) return {3'b0, sh_up};
        if (a == 16'h000A) return {sh_par, sh_mask, 7'b0, sh_pg};
        return 16'h0;
    endfunction

    task automatic ext_write(input logic [15:0] ofs, input logic [15:0] d, input string req);
        drive(1'b1, 1'b1, ofs, d);
        @(negedge clk);
        host_sel = 1'b0;
        chk({req, " we"}, mem_we, sh_mask != 2'b00);
        chk({req, " addr"}, mem_addr, exp_addr(host_wide, ofs));
        chk("R7 be/wdata/wpar", {mem_be, mem_wdata, mem_wpar}, {sh_mask, d, sh_par});
        @(negedge clk);
        chk("R7 we one cycle", mem_we, 1'b0);
    endtask

    task automatic ext_read(input logic [15:0] ofs, input string req);
        logic [32:0] ea;
        ea = exp_addr(host_wide, ofs);
        drive(1'b1, 1'b0, ofs, 16'h0);
        @(negedge clk);
        host_sel = 1'b0;
        chk("R8 re", mem_re, 1'b1);
        chk({req, " addr"}, mem_addr, ea);
        @(negedge clk);
        chk("R8 rvalid", host_rvalid, 1'b1);
        chk("R8 rdata", host_rdata, mem_fn(ea));
        chk("R8 re one cycle", mem_re, 1'b0);
        sh_rpar = par_fn(ea);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 strobes at reset", {mem_we, mem_re, host_rvalid}, 3'b000);
        rst_n = 1'b1;
        reg_read(16'h0000, v); chk("R1 status reset", v, 16'h0);
        reg_read(16'h0008, v); chk("R1 upper reset", v, 16'h0);
        reg_read(16'h000A, v); chk("R1 lower reset", v, 16'h0);

        // R2 / R3 basic 16-bit
        reg_write(16'h0008, 16'hFABC);
        reg_read(16'h0008, v); chk("R2 upper readback", v, 16'h1ABC);
        reg_write(16'h000A, 16'b10_11_1111111_0_1010);
        reg_read(16'h000A, v); chk("R5 ignored bits read zero", v, 16'b10_11_0000000_0_1010);
        host_wide = 1'b1;
        ext_write(16'h1234, 16'hBEEF, "R3");
        // R5: page bit 4 has no effect in 16-bit mode
        reg_write(16'h000A, 16'b10_11_0101010_1_1010);
        ext_read(16'h8001, "R5 bit4 16-bit");
        // R4: 8-bit mode, offset bit 15 ignored
        host_wide = 1'b0;
        ext_read(16'h8001, "R4 bit15 set");
        ext_read(16'h0001, "R4 bit15 clear");
        reg_read(16'h0000, v); chk("R9 status parity", v, {sh_rpar, 14'b0});
        // R7: mask 00 blocks write strobe
        reg_write(16'h000A, 16'h0003);
        ext_write(16'h00FF, 16'h5555, "R7 mask zero");
        // R10: page held across accesses
        ext_read(16'h0010, "R10 same page 1");
        ext_read(16'h0020, "R10 same page 2");
        reg_read(16'h0008, v); chk("R10 upper kept", v, {3'b0, sh_up});

        // R11: request during an extended read is ignored
        drive(1'b1, 1'b0, 16'h0040, 16'h0);
        @(negedge clk);
        host_das = 1'b0; host_wr = 1'b1; host_addr = 16'h0008; host_wdata = 16'h0777;
        chk("R11 read issued", mem_re, 1'b1);
        sh_rpar = par_fn(exp_addr(host_wide, 16'h0040));
        @(negedge clk);
        host_sel = 1'b0;
        chk("R11 read answered", host_rvalid, 1'b1);
        @(negedge clk);
        reg_read(16'h0008, v); chk("R11 busy write ignored", v, {3'b0, sh_up});

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [15:0] r;
            op = int'($urandom_range(0, 5));
            r  = 16'($urandom);
            host_wide = 1'($urandom);
            unique case (op)
                0: reg_write(16'h0008, r);
                1: reg_write(16'h000A, r);
                2: ext_write(16'($urandom), r, host_wide ? "R3" : "R4");
                3: ext_read(16'($urandom), host_wide ? "R3" : "R4");
                4: begin
                    logic [15:0] a;
                    a = ($urandom_range(0, 2) == 0) ? 16'h0000 :
                        ($urandom_range(0, 1) == 0) ? 16'h0008 : 16'h000A;
                    reg_read(a, v);
                    chk("R9 R2 R5 random readback", v, exp_reg(a));
                end
                default: begin
                    reg_write(16'h0004, r);
                    reg_read(16'h0004, v); chk("R6 unmapped reads zero", v, 16'h0);
                end
            endcase
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule